// File: doc/BRIEF.md
# Privilege-Level Interrupt Routing Cascade

This block works out which privilege level should take the next local interrupt: machine, hypervisor-supervisor (HS) or virtual-supervisor (VS). It starts from the hart's pending and enable vectors and its guest-external pending lines. It applies the two delegation masks and the per-level global enables, then hands the winning level's candidate vector to a priority selector outside the block. It also passes the index and default priority of that level's external interrupt, which the selector uses for arbitration.

The levels are tried in a fixed order. Machine is tried first, then HS, then VS. A later level is considered only when every earlier level has no candidate. VS candidates are shifted down one bit before they go to the selector. When the selector returns an index, the block shifts that index back up by one and reports the final interrupt number. Routing results are registered, so they appear one cycle after the inputs. The number correction is combinational on the registered level.

Top module: `irq_route_top`

## Requirements
- R1: The effective pending vector is the pending input ANDed with the enable input. Before the AND, bit 10 (VS external) is also set when the select field is below the number of guest-external lines and the guest-external line it selects is set. A select value that is out of range adds nothing.
- R2: With virtualization on, machine and HS interrupts are always enabled. VS interrupts are enabled when the privilege code is 0 (user), or when it is 1 (supervisor) with the supervisor global enable set.
- R3: With virtualization off, VS interrupts are disabled. Machine interrupts are enabled when the privilege code is below 3, or when it is 3 with the machine global enable set. HS interrupts are enabled when the code is 0, or when it is 1 with the supervisor global enable set.
- R4: Machine candidates are effective pending bits that are clear in the machine delegation mask. If any exist and machine is enabled, the level code is 3 and the candidate output carries them unshifted.
- R5: HS candidates are effective pending bits that are set in the machine mask and clear in the hypervisor mask. HS is chosen (level code 1) only when there are no machine candidates. The candidates are output unshifted.
- R6: VS candidates are effective pending bits set in both masks. VS is chosen (level code 2) only when there are no machine and no HS candidates. The candidate output is the VS set shifted right by one bit, so it may be zero when only bit 0 was pending.
- R7: For the machine level the external index output is 11, with the machine default priority parameter. For HS and VS it is 9, with the supervisor default priority parameter. With no level chosen, both are 0.
- R8: The interrupt number equals the selector index, plus one when the level is VS and the index is nonzero. The interrupt valid output is high only when the selector valid input and the route valid output are both high.
- R9: When no level has candidates, the route valid output is low, the level code is 0 and the candidate output is zero.
- R10: Routing outputs change exactly one clock after the inputs. A synchronous reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NIRQ | Pending interrupt vector |
| en_i | input | NIRQ | Interrupt enable vector |
| mdeleg_i | input | NIRQ | Machine delegation mask |
| hdeleg_i | input | NIRQ | Hypervisor delegation mask |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization active |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| gext_i | input | GEXT_N | Guest-external pending lines |
| gsel_i | input | GSEL_W | Guest-external line select |
| route_level_o | output | 2 | Level code: 0 none, 1 HS, 2 VS, 3 machine |
| route_valid_o | output | 1 | A level was chosen |
| route_cand_o | output | NIRQ | Candidate vector for the selector |
| ext_num_o | output | IDX_W | External interrupt index for the selector |
| ext_dflt_o | output | 8 | External default priority for the selector |
| sel_valid_i | input | 1 | Selector result valid |
| sel_idx_i | input | IDX_W | Selector result index |
| irq_valid_o | output | 1 | Final interrupt number valid |
| irq_num_o | output | IDX_W | Corrected interrupt number |

## Verification
The VS level is the hardest outcome to reach. It needs virtualization on, both masks delegating the pending bits, no machine or HS candidates, and a low privilege or a set supervisor enable. Uniform random inputs almost never meet all of these at once. The stimulus therefore picks a scenario per vector: one scenario forces full delegation with virtualization on and user privilege, and another fills only the delegated HS part. Directed cases add VS external pending raised purely through the guest-external select path, an out-of-range select, and a VS result with selector index 0.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_HS   = 2'd1,
        LVL_VS   = 2'd2,
        LVL_M    = 2'd3
    } lvl_e;

    typedef struct packed {
        logic m_on;
        logic hs_on;
        logic vs_on;
    } lvl_en_t;

    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_SUP  = 2'd1;
    localparam logic [1:0] PRIV_MACH = 2'd3;

    localparam int SEXT_BIT  = 9;
    localparam int VSEXT_BIT = 10;
    localparam int MEXT_BIT  = 11;

    function automatic logic priv_allows(input logic [1:0] cur,
                                         input logic [1:0] lvl,
                                         input logic       gie);
        return (cur < lvl) || ((cur == lvl) && gie);
    endfunction

endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
    parameter int NIRQ   = 64,
    parameter int GEXT_N = 16,
    parameter int GSEL_W = 6
) (
    input  logic [NIRQ-1:0]   pend_i,
    input  logic [NIRQ-1:0]   en_i,
    input  logic [GEXT_N-1:0] gext_i,
    input  logic [GSEL_W-1:0] gsel_i,
    output logic [NIRQ-1:0]   eff_o
);
    import irq_route_pkg::*;

    logic [GEXT_N-1:0] hit_vec;
    logic              gext_hit;
    logic [NIRQ-1:0]   vs_ext_vec;

    // One compare per guest-external line; an out-of-range select matches none.
    for (genvar g = 0; g < GEXT_N; g++) begin : g_sel
        assign hit_vec[g] = gext_i[g] && (gsel_i == GSEL_W'(g));
    end

    assign gext_hit = |hit_vec;

    always_comb begin
        vs_ext_vec            = '0;
        vs_ext_vec[VSEXT_BIT] = gext_hit;
    end

    assign eff_o = (pend_i | vs_ext_vec) & en_i;

endmodule

// File: rtl/irq_lvl_enable.sv
module irq_lvl_enable (
    input  logic [1:0]               priv_i,
    input  logic                     virt_i,
    input  logic                     m_gie_i,
    input  logic                     s_gie_i,
    output irq_route_pkg::lvl_en_t   en_o
);
    import irq_route_pkg::*;

    always_comb begin
        if (virt_i) begin
            en_o.m_on  = 1'b1;
            en_o.hs_on = 1'b1;
            en_o.vs_on = priv_allows(priv_i, PRIV_SUP, s_gie_i);
        end else begin
            en_o.m_on  = priv_allows(priv_i, PRIV_MACH, m_gie_i);
            en_o.hs_on = priv_allows(priv_i, PRIV_SUP, s_gie_i);
            en_o.vs_on = 1'b0;
        end
    end

endmodule

// File: rtl/irq_lvl_cascade.sv
module irq_lvl_cascade #(
    parameter int         NIRQ   = 64,
    parameter int         IDX_W  = 6,
    parameter logic [7:0] M_DFLT = 8'd128,
    parameter logic [7:0] S_DFLT = 8'd192
) (
    input  logic [NIRQ-1:0]        eff_i,
    input  logic [NIRQ-1:0]        mdeleg_i,
    input  logic [NIRQ-1:0]        hdeleg_i,
    input  irq_route_pkg::lvl_en_t en_i,
    output irq_route_pkg::lvl_e    level_o,
    output logic [NIRQ-1:0]        cand_o,
    output logic [IDX_W-1:0]       ext_num_o,
    output logic [7:0]             ext_dflt_o
);
    import irq_route_pkg::*;

    logic [NIRQ-1:0] m_set;
    logic [NIRQ-1:0] hs_set;
    logic [NIRQ-1:0] vs_set;

    assign m_set  = eff_i & ~mdeleg_i & {NIRQ{en_i.m_on}};
    assign hs_set = eff_i &  mdeleg_i & ~hdeleg_i & {NIRQ{en_i.hs_on}};
    assign vs_set = eff_i &  mdeleg_i &  hdeleg_i & {NIRQ{en_i.vs_on}};

    always_comb begin
        level_o    = LVL_NONE;
        cand_o     = '0;
        ext_num_o  = '0;
        ext_dflt_o = '0;
        if (|m_set) begin
            level_o    = LVL_M;
            cand_o     = m_set;
            ext_num_o  = IDX_W'(MEXT_BIT);
            ext_dflt_o = M_DFLT;
        end else if (|hs_set) begin
            level_o    = LVL_HS;
            cand_o     = hs_set;
            ext_num_o  = IDX_W'(SEXT_BIT);
            ext_dflt_o = S_DFLT;
        end else if (|vs_set) begin
            level_o    = LVL_VS;
            cand_o     = vs_set >> 1;
            ext_num_o  = IDX_W'(SEXT_BIT);
            ext_dflt_o = S_DFLT;
        end
    end

endmodule

// File: rtl/irq_num_fixup.sv
module irq_num_fixup #(
    parameter int IDX_W = 6
) (
    input  irq_route_pkg::lvl_e level_i,
    input  logic                route_valid_i,
    input  logic                sel_valid_i,
    input  logic [IDX_W-1:0]    sel_idx_i,
    output logic                irq_valid_o,
    output logic [IDX_W-1:0]    irq_num_o
);
    import irq_route_pkg::*;

    logic lift;

    assign lift        = (level_i == LVL_VS) && (sel_idx_i != '0);
    assign irq_num_o   = lift ? sel_idx_i + IDX_W'(1) : sel_idx_i;
    assign irq_valid_o = sel_valid_i && route_valid_i;

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
    parameter int         NIRQ   = 64,
    parameter int         GEXT_N = 16,
    parameter int         GSEL_W = 6,
    parameter logic [7:0] M_DFLT = 8'd128,
    parameter logic [7:0] S_DFLT = 8'd192,
    localparam int        IDX_W  = $clog2(NIRQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIRQ-1:0]   pend_i,
    input  logic [NIRQ-1:0]   en_i,
    input  logic [NIRQ-1:0]   mdeleg_i,
    input  logic [NIRQ-1:0]   hdeleg_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              m_gie_i,
    input  logic              s_gie_i,
    input  logic [GEXT_N-1:0] gext_i,
    input  logic [GSEL_W-1:0] gsel_i,
    output logic [1:0]        route_level_o,
    output logic              route_valid_o,
    output logic [NIRQ-1:0]   route_cand_o,
    output logic [IDX_W-1:0]  ext_num_o,
    output logic [7:0]        ext_dflt_o,
    input  logic              sel_valid_i,
    input  logic [IDX_W-1:0]  sel_idx_i,
    output logic              irq_valid_o,
    output logic [IDX_W-1:0]  irq_num_o
);
    import irq_route_pkg::*;

    logic [NIRQ-1:0]  eff;
    lvl_en_t          lvl_en;
    lvl_e             level_d, level_q;
    logic [NIRQ-1:0]  cand_d, cand_q;
    logic [IDX_W-1:0] ext_num_d, ext_num_q;
    logic [7:0]       ext_dflt_d, ext_dflt_q;

    irq_pend_merge #(.NIRQ(NIRQ), .GEXT_N(GEXT_N), .GSEL_W(GSEL_W)) u_merge (
        .pend_i (pend_i),
        .en_i   (en_i),
        .gext_i (gext_i),
        .gsel_i (gsel_i),
        .eff_o  (eff)
    );

    irq_lvl_enable u_enable (
        .priv_i  (priv_i),
        .virt_i  (virt_i),
        .m_gie_i (m_gie_i),
        .s_gie_i (s_gie_i),
        .en_o    (lvl_en)
    );

    irq_lvl_cascade #(.NIRQ(NIRQ), .IDX_W(IDX_W), .M_DFLT(M_DFLT), .S_DFLT(S_DFLT)) u_cascade (
        .eff_i      (eff),
        .mdeleg_i   (mdeleg_i),
        .hdeleg_i   (hdeleg_i),
        .en_i       (lvl_en),
        .level_o    (level_d),
        .cand_o     (cand_d),
        .ext_num_o  (ext_num_d),
        .ext_dflt_o (ext_dflt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q    <= LVL_NONE;
            cand_q     <= '0;
            ext_num_q  <= '0;
            ext_dflt_q <= '0;
        end else begin
            level_q    <= level_d;
            cand_q     <= cand_d;
            ext_num_q  <= ext_num_d;
            ext_dflt_q <= ext_dflt_d;
        end
    end

    assign route_level_o = level_q;
    assign route_valid_o = (level_q != LVL_NONE);
    assign route_cand_o  = cand_q;
    assign ext_num_o     = ext_num_q;
    assign ext_dflt_o    = ext_dflt_q;

    irq_num_fixup #(.IDX_W(IDX_W)) u_fixup (
        .level_i       (level_q),
        .route_valid_i (route_valid_o),
        .sel_valid_i   (sel_valid_i),
        .sel_idx_i     (sel_idx_i),
        .irq_valid_o   (irq_valid_o),
        .irq_num_o     (irq_num_o)
    );

    AST_VS_NEEDS_VIRT: assert property (@(posedge clk) disable iff (rst)
        (level_q == LVL_VS) |-> $past(virt_i)); // R3

    AST_HS_DELEG_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (level_q == LVL_HS) |-> (((cand_q & ~$past(mdeleg_i)) == '0) &&
                                 ((cand_q &  $past(hdeleg_i)) == '0))); // R5

    AST_M_UNDELEGATED: assert property (@(posedge clk) disable iff (rst)
        (level_q == LVL_M) |-> ((cand_q & $past(mdeleg_i)) == '0) && (cand_q != '0)); // R4

    AST_VS_NUM_SKIPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (irq_valid_o && level_q == LVL_VS) |-> (irq_num_o != IDX_W'(1))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !route_valid_o |-> (cand_q == '0) && !irq_valid_o && (ext_num_q == '0)); // R9

    AST_EXT_HINT: assert property (@(posedge clk) disable iff (rst)
        (level_q == LVL_HS || level_q == LVL_VS) |-> (ext_dflt_q == S_DFLT)); // R7

endmodule

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
    localparam int NIRQ   = 64;
    localparam int GEXT_N = 16;
    localparam int GSEL_W = 6;
    localparam int IDX_W  = 6;
    localparam logic [7:0] M_DF = 8'd128;
    localparam logic [7:0] S_DF = 8'd192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIRQ-1:0] pend, en, mdel, hdel;
    logic [1:0] priv;
    logic virt, mgie, sgie;
    logic [GEXT_N-1:0] gext;
    logic [GSEL_W-1:0] gsel;
    logic [1:0] lvl_o;
    logic rvalid_o;
    logic [NIRQ-1:0] cand_o;
    logic [IDX_W-1:0] enum_o;
    logic [7:0] edflt_o;
    logic selv;
    logic [IDX_W-1:0] seli;
    logic ivalid_o;
    logic [IDX_W-1:0] inum_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_route_top #(.NIRQ(NIRQ), .GEXT_N(GEXT_N), .GSEL_W(GSEL_W),
                    .M_DFLT(M_DF), .S_DFLT(S_DF)) u_dut (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .mdeleg_i(mdel),
        .hdeleg_i(hdel), .priv_i(priv), .virt_i(virt), .m_gie_i(mgie),
        .s_gie_i(sgie), .gext_i(gext), .gsel_i(gsel), .route_level_o(lvl_o),
        .route_valid_o(rvalid_o), .route_cand_o(cand_o), .ext_num_o(enum_o),
        .ext_dflt_o(edflt_o), .sel_valid_i(selv), .sel_idx_i(seli),
        .irq_valid_o(ivalid_o), .irq_num_o(inum_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [1:0]       x_lvl;
    logic [NIRQ-1:0]  x_cand;
    logic [IDX_W-1:0] x_num;
    logic [7:0]       x_dflt;

    // Expected routing from the requirement text.
    task automatic model();
        logic [NIRQ-1:0] eff, mc, hc, vc;
        logic mon, hon, von;
        eff = pend;
        if (gsel < GEXT_N && gext[gsel]) eff[10] = 1'b1;      // R1
        eff = eff & en;
        if (virt) begin                                        // R2
            mon = 1'b1; hon = 1'b1;
            von = (priv == 2'd0) || (priv == 2'd1 && sgie);
        end else begin                                         // R3
            mon = (priv < 2'd3) || (priv == 2'd3 && mgie);
            hon = (priv == 2'd0) || (priv == 2'd1 && sgie);
            von = 1'b0;
        end
        mc = mon ? (eff & ~mdel) : '0;
        hc = hon ? (eff & mdel & ~hdel) : '0;
        vc = von ? (eff & mdel & hdel) : '0;
        if (mc != 0)      begin x_lvl = 2'd3; x_cand = mc;      x_num = 6'd11; x_dflt = M_DF; end
        else if (hc != 0) begin x_lvl = 2'd1; x_cand = hc;      x_num = 6'd9;  x_dflt = S_DF; end
        else if (vc != 0) begin x_lvl = 2'd2; x_cand = vc >> 1; x_num = 6'd9;  x_dflt = S_DF; end
        else              begin x_lvl = 2'd0; x_cand = '0;      x_num = 6'd0;  x_dflt = 8'd0; end
    endtask

    // Inputs are already set at a negedge; check one clock later (R10).
    task automatic apply_check(input logic sv, input logic [IDX_W-1:0] si);
        logic [IDX_W-1:0] xn;
        model();
        selv = 1'b0;
        @(negedge clk);
        chk("R4/R5/R6 level", "level", 64'(lvl_o), 64'(x_lvl));
        chk("R9 valid", "valid", 64'(rvalid_o), 64'(x_lvl != 2'd0));
        chk("R6 cand", "cand", cand_o, x_cand);
        chk("R7 ext", "ext_num", 64'(enum_o), 64'(x_num));
        chk("R7 dflt", "ext_dflt", 64'(edflt_o), 64'(x_dflt));
        selv = sv; seli = si;
        #1;
        xn = (x_lvl == 2'd2 && si != 0) ? si + 6'd1 : si;
        chk("R8 num", "irq_num", 64'(inum_o), 64'(xn));
        chk("R8 ivalid", "irq_valid", 64'(ivalid_o), 64'(sv && x_lvl != 2'd0));
    endtask

    task automatic clear_in();
        pend = '0; en = '1; mdel = '0; hdel = '0; priv = 2'd0;
        virt = 1'b0; mgie = 1'b0; sgie = 1'b0; gext = '0; gsel = '0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        clear_in();
        selv = 1'b0; seli = '0;
        pend = '1; en = '1;
        repeat (3) @(negedge clk);
        // R10: reset holds everything clear
        chk("R10 reset", "level", 64'(lvl_o), 0);
        chk("R10 reset", "cand", cand_o, 0);
        chk("R10 reset", "ext_num", 64'(enum_o), 0);
        rst = 1'b0;

        // R4: machine wins over pending VS
        clear_in(); virt = 1'b1; pend = 64'h0000_0000_0000_0884;
        mdel = 64'h0000_0000_0000_0404; hdel = 64'h0000_0000_0000_0404;
        apply_check(1'b1, 6'd11);
        chk("R4 direct", "level", 64'(lvl_o), 64'd3);

        // R1/R6: VS external raised only through guest-external select
        @(negedge clk);
        clear_in(); virt = 1'b1; mdel = '1; hdel = '1; gext = 16'h0020; gsel = 6'd5;
        apply_check(1'b1, 6'd9);
        chk("R1 gext", "cand", cand_o, 64'h200);
        chk("R8 vs lift", "irq_num", 64'(inum_o), 64'd10);

        // R1: out-of-range select adds nothing
        @(negedge clk);
        gext = '1; gsel = 6'd40;
        apply_check(1'b0, 6'd0);
        chk("R1 range", "valid", 64'(rvalid_o), 0);

        // R8: VS with selector index 0 stays 0
        @(negedge clk);
        clear_in(); virt = 1'b1; mdel = '1; hdel = '1; pend = 64'h3;
        apply_check(1'b1, 6'd0);
        chk("R8 zero", "irq_num", 64'(inum_o), 0);

        // R3: machine privilege with machine enable off, no virtualization
        @(negedge clk);
        clear_in(); priv = 2'd3; pend = 64'h888; mdel = 64'h8;
        apply_check(1'b1, 6'd3);
        chk("R3 mdis", "level", 64'(lvl_o), 0);

        // R2: supervisor with enable off blocks VS
        @(negedge clk);
        clear_in(); virt = 1'b1; priv = 2'd1; mdel = '1; hdel = '1; pend = 64'h400;
        apply_check(1'b0, 6'd0);
        chk("R2 vsdis", "level", 64'(lvl_o), 0);

        // Random scenarios biased toward each level
        for (int i = 0; i < 600; i++) begin
            int sc;
            @(negedge clk);
            sc   = $urandom % 4;
            pend = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            en   = {$urandom, $urandom} | {$urandom, $urandom};
            mdel = {$urandom, $urandom};
            hdel = {$urandom, $urandom};
            priv = 2'($urandom);
            virt = 1'($urandom);
            mgie = 1'($urandom);
            sgie = 1'($urandom);
            gext = 16'($urandom);
            gsel = 6'($urandom % 20);
            case (sc)
                1: begin mdel = '1; virt = 1'b1; end
                2: begin mdel = '1; hdel = '1; virt = 1'b1; priv = 2'd0; end
                3: virt = 1'b0;
                default: ;
            endcase
            apply_check(1'($urandom), 6'($urandom));
        end

        // R10: mid-run reset clears outputs
        @(negedge clk);
        clear_in(); pend = '1; rst = 1'b1;
        @(negedge clk);
        chk("R10 midreset", "valid", 64'(rvalid_o), 0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule